// File: doc/BRIEF.md
# Edge-Cause GPIO Controller

This block drives and samples up to 32 general-purpose pins through a simple 32-bit register bus. Each access picks one of four address windows and a byte offset in that window. Software never writes the output-enable or output-data state directly. It sets bits through one window and clears them through another, so concurrent users never need a read-modify-write of shared state.

Pin inputs are resynchronised to the block clock. A change of the synchronised level is an edge. Each pin has its own rising and falling qualifiers. A qualified edge latches a per-pin cause bit. A per-pin event enable decides which cause bits reach the single level-sensitive interrupt line and which bits appear when the cause register is read. Software acknowledges causes by writing ones.

The pin count is a parameter from 1 to 32. Typical instances use 32 pins and 24 pins.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: In the set window (bus_win = 2), a write at offset 0x04 sets the output-enable bit of every pin whose data bit is 1. A write at offset 0x00 does the same for the output-data bits. Bits written as 0 are unchanged. The new value shows on pin_oe / pin_out in the cycle after the write.
- R2: In the clear window (bus_win = 3), a write at offset 0x04 clears the output-enable bit of every pin whose data bit is 1. A write at offset 0x00 does the same for the output-data bits. Bits written as 0 are unchanged.
- R3: In the main window (bus_win = 0), offset 0x00 is a read/write rising-edge qualifier mask and offset 0x04 is a read/write falling-edge qualifier mask.
- R4: Main window offset 0x08 reads the pin levels through a two-flop synchroniser. A pin change applied after clock edge k is first read after edge k+2.
- R5: A pin whose rising qualifier is set latches its cause bit on a rise of the synchronised level. A pin whose falling qualifier is set latches it on a fall. A pin with both qualifiers set latches it on either edge. The cause bit is set at edge k+3 for a pin change applied after edge k, whatever the event enable holds. Qualifiers are sampled in the edge cycle.
- R6: In the cause window (bus_win = 1), offset 0x14 is a read/write per-pin event enable mask. A read at offset 0x00 returns the cause bits ANDed with that mask.
- R7: A write at cause window offset 0x18 clears every cause bit whose data bit is 1. Bits written as 0 keep their cause.
- R8: irq is high exactly while some cause bit with its event enable set is pending. It drops only after a write to the cause window.
- R9: When a qualified edge and an acknowledge of the same bit fall in the same cycle, the cause bit stays set.
- R10: Every other offset reads zero, and so do the set and clear windows and bus_rdata while bus_sel is low. Register bits at and above the pin count read zero, and writes to them have no effect.
- R11: After reset, all qualifier masks, event enables, cause bits, output enables and output data are zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_win | input | 2 | Window: 0 main, 1 cause, 2 set, 3 clear |
| bus_addr | input | 8 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current request |
| pin_in | input | N_PINS | Asynchronous pin levels |
| pin_oe | output | N_PINS | Output-enable per pin |
| pin_out | output | N_PINS | Output data per pin |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds two instances from the same stimulus, one with 32 pins and one with 24. The 32-pin instance exercises every register bit, including bit 31 of each mask. The 24-pin instance shows that data written to bits 24 to 31 is discarded, that those bits read as zero, and that edges on pins it does not have cannot reach its interrupt. A single reference model serves both instances, since the narrow one is expected to equal the wide one masked to 24 bits.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int MAX_PINS = 32;

    typedef enum logic [1:0] {
        WIN_MAIN  = 2'd0,
        WIN_CAUSE = 2'd1,
        WIN_SET   = 2'd2,
        WIN_CLR   = 2'd3
    } win_e;

    // main window
    localparam logic [7:0] OFS_RISE_EN = 8'h00;
    localparam logic [7:0] OFS_FALL_EN = 8'h04;
    localparam logic [7:0] OFS_LEVEL   = 8'h08;
    // cause window
    localparam logic [7:0] OFS_PENDING = 8'h00;
    localparam logic [7:0] OFS_EVT_EN  = 8'h14;
    localparam logic [7:0] OFS_ACK     = 8'h18;
    // set / clear windows
    localparam logic [7:0] OFS_DRV_DATA = 8'h00;
    localparam logic [7:0] OFS_DRV_OE   = 8'h04;

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_i,
    output logic [N_PINS-1:0] level_o,
    output logic [N_PINS-1:0] rise_o,
    output logic [N_PINS-1:0] fall_o
);

    typedef struct packed {
        logic [N_PINS-1:0] meta;
        logic [N_PINS-1:0] stable;
        logic [N_PINS-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = pin_i;
        st_d.stable = st_q.meta;
        st_d.prev   = st_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.stable;
    assign rise_o  = st_q.stable & ~st_q.prev;
    assign fall_o  = ~st_q.stable & st_q.prev;

endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] hit_i,
    input  logic [N_PINS-1:0] ack_i,
    input  logic              en_we_i,
    input  logic [N_PINS-1:0] en_wdata_i,
    output logic [N_PINS-1:0] en_o,
    output logic [N_PINS-1:0] pend_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [N_PINS-1:0] cause;
        logic [N_PINS-1:0] evt_en;
    } cause_t;

    cause_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.cause = (st_q.cause & ~ack_i) | hit_i;
        if (en_we_i) st_d.evt_en = en_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.evt_en;
    assign pend_o = st_q.cause & st_q.evt_en;
    assign irq_o  = |pend_o;

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i & ~hit_i) != '0 |=> (st_q.cause & $past(ack_i & ~hit_i)) == '0);

    // R9
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i != '0 |=> (st_q.cause & $past(hit_i)) == $past(hit_i));

    // R8
    irq_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(hit_i) != '0) || $past(en_we_i));

endmodule

// File: rtl/gpio_edge_outctl.sv
module gpio_edge_outctl #(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] oe_set_i,
    input  logic [N_PINS-1:0] oe_clr_i,
    input  logic [N_PINS-1:0] dat_set_i,
    input  logic [N_PINS-1:0] dat_clr_i,
    output logic [N_PINS-1:0] oe_o,
    output logic [N_PINS-1:0] dat_o
);

    typedef struct packed {
        logic [N_PINS-1:0] oe;
        logic [N_PINS-1:0] dat;
    } drv_t;

    drv_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.oe  = (st_q.oe  | oe_set_i)  & ~oe_clr_i;
        st_d.dat = (st_q.dat | dat_set_i) & ~dat_clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oe_o  = st_q.oe;
    assign dat_o = st_q.dat;

    // R1
    oe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_set_i != '0 |=> (oe_o & $past(oe_set_i)) == $past(oe_set_i));

    // R2
    oe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_clr_i != '0 |=> (oe_o & $past(oe_clr_i)) == '0);

    // R2
    dat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_clr_i != '0 |=> (dat_o & $past(dat_clr_i)) == '0);

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_win,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_oe,
    output logic [N_PINS-1:0] pin_out,
    output logic              irq
);

    typedef struct packed {
        logic [N_PINS-1:0] rise_en;
        logic [N_PINS-1:0] fall_en;
    } qual_t;

    qual_t q_d, q_q;

    win_e              win;
    logic              wr_main, wr_cause, wr_set, wr_clr;
    logic [N_PINS-1:0] wdat;
    logic [N_PINS-1:0] level, rise, fall, hit, ack;
    logic [N_PINS-1:0] evt_en, pending;
    logic [N_PINS-1:0] rd_n;

    assign win      = win_e'(bus_win);
    assign wdat     = bus_wdata[N_PINS-1:0];
    assign wr_main  = bus_sel && bus_wr && (win == WIN_MAIN);
    assign wr_cause = bus_sel && bus_wr && (win == WIN_CAUSE);
    assign wr_set   = bus_sel && bus_wr && (win == WIN_SET);
    assign wr_clr   = bus_sel && bus_wr && (win == WIN_CLR);

    gpio_edge_sync #(.N_PINS(N_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_in),
        .level_o (level),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    always_comb begin
        q_d = q_q;
        if (wr_main && bus_addr == OFS_RISE_EN) q_d.rise_en = wdat;
        if (wr_main && bus_addr == OFS_FALL_EN) q_d.fall_en = wdat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign hit = (rise & q_q.rise_en) | (fall & q_q.fall_en);
    assign ack = (wr_cause && bus_addr == OFS_ACK) ? wdat : '0;

    gpio_edge_cause #(.N_PINS(N_PINS)) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit),
        .ack_i      (ack),
        .en_we_i    (wr_cause && bus_addr == OFS_EVT_EN),
        .en_wdata_i (wdat),
        .en_o       (evt_en),
        .pend_o     (pending),
        .irq_o      (irq)
    );

    gpio_edge_outctl #(.N_PINS(N_PINS)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .oe_set_i  ((wr_set && bus_addr == OFS_DRV_OE)   ? wdat : '0),
        .oe_clr_i  ((wr_clr && bus_addr == OFS_DRV_OE)   ? wdat : '0),
        .dat_set_i ((wr_set && bus_addr == OFS_DRV_DATA) ? wdat : '0),
        .dat_clr_i ((wr_clr && bus_addr == OFS_DRV_DATA) ? wdat : '0),
        .oe_o      (pin_oe),
        .dat_o     (pin_out)
    );

    always_comb begin
        rd_n = '0;
        if (bus_sel) begin
            unique case (win)
                WIN_MAIN: begin
                    if (bus_addr == OFS_RISE_EN)      rd_n = q_q.rise_en;
                    else if (bus_addr == OFS_FALL_EN) rd_n = q_q.fall_en;
                    else if (bus_addr == OFS_LEVEL)   rd_n = level;
                end
                WIN_CAUSE: begin
                    if (bus_addr == OFS_PENDING)     rd_n = pending;
                    else if (bus_addr == OFS_EVT_EN) rd_n = evt_en;
                end
                default: rd_n = '0;
            endcase
        end
    end

    assign bus_rdata = 32'(rd_n);

    // R8
    irq_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_cause));

endmodule

// File: tb/gpio_edge_ctrl_tb.sv
module gpio_edge_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [1:0]  win = 2'd0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] pins = '0;
    logic [31:0] rd32, rd24w;
    logic [31:0] oe32, out32;
    logic [23:0] rd24, oe24, out24;
    logic        irq32, irq24;
    logic        done = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [31:0] MASK24 = 32'h00FF_FFFF;

    always #4 clk = ~clk;

    gpio_edge_ctrl #(.N_PINS(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_win(win),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd32), .pin_in(pins),
        .pin_oe(oe32), .pin_out(out32), .irq(irq32)
    );

    gpio_edge_ctrl #(.N_PINS(24)) u_dut24 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_win(win),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd24w), .pin_in(pins[23:0]),
        .pin_oe(oe24), .pin_out(out24), .irq(irq24)
    );

    // reference model state
    logic [31:0] m_rise, m_fall, m_en, m_cause, m_oe, m_dout;
    logic [31:0] hist[$];

    initial begin
        m_rise = '0; m_fall = '0; m_en = '0; m_cause = '0; m_oe = '0; m_dout = '0;
        hist = '{32'h0, 32'h0, 32'h0};
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rise = '0; m_fall = '0; m_en = '0; m_cause = '0; m_oe = '0; m_dout = '0;
            hist = '{32'h0, 32'h0, 32'h0};
        end else begin
            logic [31:0] up, dn, ackv;
            up   = hist[1] & ~hist[2];
            dn   = ~hist[1] & hist[2];
            ackv = (sel && wr && win == 2'd1 && addr == 8'h18) ? wdata : 32'h0;
            m_cause = (m_cause & ~ackv) | (up & m_rise) | (dn & m_fall);
            if (sel && wr) begin
                case (win)
                    2'd0: begin
                        if (addr == 8'h00) m_rise = wdata;
                        if (addr == 8'h04) m_fall = wdata;
                    end
                    2'd1: if (addr == 8'h14) m_en = wdata;
                    2'd2: begin
                        if (addr == 8'h04) m_oe   = m_oe | wdata;
                        if (addr == 8'h00) m_dout = m_dout | wdata;
                    end
                    default: begin
                        if (addr == 8'h04) m_oe   = m_oe & ~wdata;
                        if (addr == 8'h00) m_dout = m_dout & ~wdata;
                    end
                endcase
            end
            hist.push_front(pins);
            void'(hist.pop_back());
        end
    end

    function automatic logic [31:0] exp_rd();
        if (!sel) return 32'h0;
        case (win)
            2'd0: begin
                if (addr == 8'h00) return m_rise;
                if (addr == 8'h04) return m_fall;
                if (addr == 8'h08) return hist[1];
                return 32'h0;
            end
            2'd1: begin
                if (addr == 8'h00) return m_cause & m_en;
                if (addr == 8'h14) return m_en;
                return 32'h0;
            end
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag();
        if (!sel) return "R10";
        if (win == 2'd0 && (addr == 8'h00 || addr == 8'h04)) return "R3";
        if (win == 2'd0 && addr == 8'h08) return "R4";
        if (win == 2'd1 && (addr == 8'h00 || addr == 8'h14)) return "R6";
        return "R10";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    assign rd24 = rd24w[23:0];

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(rd_tag(), rd32, exp_rd());
            chk({rd_tag(), "/R10"}, rd24w, exp_rd() & MASK24);
            chk("R1/R2 oe", oe32, m_oe);
            chk("R1/R2 data", out32, m_dout);
            chk("R1/R2/R10 oe24", {8'h0, oe24}, m_oe & MASK24);
            chk("R1/R2/R10 data24", {8'h0, out24}, m_dout & MASK24);
            chk("R8", {31'h0, irq32}, {31'h0, |(m_cause & m_en)});
            chk("R8/R10", {31'h0, irq24}, {31'h0, |(m_cause & m_en & MASK24)});
        end
    end

    task automatic drive(input logic s, input logic w, input logic [1:0] wn,
                         input logic [7:0] a, input logic [31:0] d);
        @(posedge clk);
        #1;
        sel = s; wr = w; win = wn; addr = a; wdata = d;
    endtask

    task automatic wr_reg(input logic [1:0] wn, input logic [7:0] a, input logic [31:0] d);
        drive(1'b1, 1'b1, wn, a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 2'd0, 8'h00, 32'h0);
    endtask

    task automatic rd_reg(input string tag, input logic [1:0] wn, input logic [7:0] a,
                          input logic [31:0] exp);
        drive(1'b1, 1'b0, wn, a, 32'h0);
        @(negedge clk);
        chk(tag, rd32, exp);
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(posedge clk);
        #1;
        pins = v;
        sel = 1'b0; wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R11 watchdog expired: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 oe", oe32, 32'h0);
        chk("R11 data", out32, 32'h0);
        chk("R11 irq", {31'h0, irq32}, 32'h0);
        rd_reg("R11 rise mask", 2'd0, 8'h00, 32'h0);
        rd_reg("R11 fall mask", 2'd0, 8'h04, 32'h0);
        rd_reg("R11 evt enable", 2'd1, 8'h14, 32'h0);
        rd_reg("R11 pending", 2'd1, 8'h00, 32'h0);

        // R1 / R2 set and clear windows
        wr_reg(2'd2, 8'h04, 32'hA5A5_00FF);
        wr_reg(2'd2, 8'h00, 32'h0F0F_F0F0);
        wr_reg(2'd2, 8'h04, 32'h0000_0000);
        idle(1);
        chk("R1 oe set", oe32, 32'hA5A5_00FF);
        chk("R1 data set", out32, 32'h0F0F_F0F0);
        wr_reg(2'd3, 8'h04, 32'h8000_00F0);
        wr_reg(2'd3, 8'h00, 32'hFFFF_0000);
        wr_reg(2'd3, 8'h00, 32'h0000_0000);
        idle(1);
        chk("R2 oe clear", oe32, 32'h25A5_000F);
        chk("R2 data clear", out32, 32'h0000_F0F0);

        // R3 qualifier masks
        wr_reg(2'd0, 8'h00, 32'h1234_5678);
        wr_reg(2'd0, 8'h04, 32'h8765_4321);
        rd_reg("R3 rise mask", 2'd0, 8'h00, 32'h1234_5678);
        rd_reg("R3 fall mask", 2'd0, 8'h04, 32'h8765_4321);

        // R4 synchronised level, two-edge latency
        set_pins(32'hDEAD_BEEF);
        rd_reg("R4 level latency", 2'd0, 8'h08, 32'h0);
        rd_reg("R4 level", 2'd0, 8'h08, 32'hDEAD_BEEF);
        set_pins(32'h0);
        idle(4);
        wr_reg(2'd1, 8'h18, 32'hFFFF_FFFF);
        idle(1);

        // R5 edge qualification: bit0 rise, bit1 both, bit2 fall, bit31 rise
        wr_reg(2'd0, 8'h00, 32'h8000_0003);
        wr_reg(2'd0, 8'h04, 32'h0000_0006);
        wr_reg(2'd1, 8'h14, 32'h0);
        set_pins(32'h8000_000F);
        idle(3);
        wr_reg(2'd1, 8'h14, 32'hFFFF_FFFF);
        rd_reg("R5 rising causes", 2'd1, 8'h00, 32'h8000_0003);
        wr_reg(2'd1, 8'h18, 32'hFFFF_FFFF);
        set_pins(32'h0);
        idle(3);
        rd_reg("R5 falling causes", 2'd1, 8'h00, 32'h0000_0006);

        // R6 masked readback
        wr_reg(2'd1, 8'h14, 32'h0000_0002);
        rd_reg("R6 masked pending", 2'd1, 8'h00, 32'h0000_0002);
        rd_reg("R6 enable readback", 2'd1, 8'h14, 32'h0000_0002);
        wr_reg(2'd1, 8'h14, 32'hFFFF_FFFF);

        // R7 acknowledge
        wr_reg(2'd1, 8'h18, 32'h0);
        rd_reg("R7 zero ack", 2'd1, 8'h00, 32'h0000_0006);
        wr_reg(2'd1, 8'h18, 32'h0000_0002);
        rd_reg("R7 partial ack", 2'd1, 8'h00, 32'h0000_0004);
        chk("R8 irq held", {31'h0, irq32}, 32'h1);
        wr_reg(2'd1, 8'h18, 32'h0000_0004);
        idle(1);
        chk("R8 irq dropped", {31'h0, irq32}, 32'h0);

        // R9 edge and ack on the same bit in the same cycle
        set_pins(32'h0000_0001);
        idle(1);
        wr_reg(2'd1, 8'h18, 32'h0000_0001);
        rd_reg("R9 edge wins", 2'd1, 8'h00, 32'h0000_0001);
        set_pins(32'h0);
        idle(3);
        wr_reg(2'd1, 8'h18, 32'hFFFF_FFFF);

        // R10 unmapped and write-only windows
        rd_reg("R10 main 0x0C", 2'd0, 8'h0C, 32'h0);
        rd_reg("R10 cause 0x04", 2'd1, 8'h04, 32'h0);
        rd_reg("R10 cause ack", 2'd1, 8'h18, 32'h0);
        rd_reg("R10 set window", 2'd2, 8'h04, 32'h0);
        rd_reg("R10 clear window", 2'd3, 8'h00, 32'h0);
        wr_reg(2'd0, 8'h00, 32'hFFFF_FFFF);
        drive(1'b1, 1'b0, 2'd0, 8'h00, 32'h0);
        @(negedge clk);
        chk("R10 upper bits 24-pin", rd24w, 32'h00FF_FFFF);

        // mixed traffic
        for (int i = 0; i < 600; i++) begin
            int unsigned r;
            logic [7:0] ofs;
            r = $urandom;
            case (r % 5)
                0: ofs = 8'h00;
                1: ofs = 8'h04;
                2: ofs = 8'h08;
                3: ofs = 8'h14;
                default: ofs = 8'h18;
            endcase
            if ((r >> 4) % 3 == 0) set_pins(pins ^ $urandom);
            else drive((r >> 8) % 4 != 0, r[10], r[12:11], ofs, $urandom);
        end
        idle(4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule